// File: doc/BRIEF.md
# Magnitude Merge and Quadruple Unit

This block is a multicycle 8-bit datapath with a start/done handshake. When started, it captures an unsigned operand X into register A and a signed operand Y into register B. If B is negative, B is first replaced by its two's complement, so B holds the unsigned magnitude |Y|. A value of -128 becomes 128.

The block then closes the gap between the two registers. On each pass it compares them. While A is below B, A counts up and B counts down in the same cycle. Once A is no longer below B, A is moved into an output shift register and shifted left twice. The output is therefore four times the meeting point, truncated to 8 bits: 4*ceil((X+|Y|)/2) when X < |Y|, and 4*X otherwise.

A nine-state one-hot sequencer runs the work. It is steered by two condition bits: the sign bit of B, and the flag "A is not below B". Done is high while the block waits for start. A caller pulses start and then waits for done to return high.

Top module: `absconv_scale`

## Requirements
- R1: After reset, done is 1, z is 0 and the sequencer is in its idle state (exactly one state bit, the idle bit, set).
- R2: While idle with start low, the block stays idle, done stays 1 and z keeps its value.
- R3: A start sampled high while idle causes done to read 0 from the second clock edge after that sample until the operation ends.
- R4: When Y[7] is 1, B becomes the 8-bit two's complement of Y, read as an unsigned magnitude (Y = -128 gives 128). When Y[7] is 0, no negate cycle is spent.
- R5: In each loop pass, when the unsigned A is below B, A increases by 1 and B decreases by 1 in the same cycle. The loop exits as soon as A >= B.
- R6: On loop exit, z is loaded from A and then shifted left by one bit in each of the next two cycles, so z = 4*A mod 256.
- R7: The reported z equals (4*ceil((X+|Y|)/2)) mod 256 when X < |Y|, and (4*X) mod 256 otherwise.
- R8: Done returns to 1 exactly 6 + n + 2*s clock edges after the edge that samples start. Here n is 1 for negative Y and 0 otherwise, and s is ceil((|Y|-X)/2) when X < |Y|, else 0.
- R9: Exactly one sequencer state bit is set at every clock edge after reset.
- R10: Start pulses while an operation is in progress are ignored: the result and the latency are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| x_in | input | 8 | Unsigned operand X |
| y_in | input | 8 | Signed operand Y (two's complement) |
| z | output | 8 | Result register, valid when done is high |
| done | output | 1 | High while idle / result ready |

## Verification
The increment of A and the decrement of B land in the same loop cycle. A slip in either one shifts the meeting point, so each step's effect shows up in z and in the latency. The bench provokes this with gaps between X and |Y| of both parities, including an odd gap where the two registers cross rather than meet, and the -128 case where the gap is widest. Every result is judged against a closed-form model of the meeting point and the cycle count, and the checker additionally confirms each step moved both registers by exactly one.

// File: rtl/absconv_pkg.sv
package absconv_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned NS = 9;

  // one-hot state indices; the sequence order is the behaviour
  localparam int unsigned ST_IDLE = 0;
  localparam int unsigned ST_LOAD = 1;
  localparam int unsigned ST_SIGN = 2;
  localparam int unsigned ST_NEG  = 3;
  localparam int unsigned ST_CMP  = 4;
  localparam int unsigned ST_STEP = 5;
  localparam int unsigned ST_ZLD  = 6;
  localparam int unsigned ST_SH1  = 7;
  localparam int unsigned ST_SH2  = 8;

  function automatic logic [DW-1:0] f_negate(input logic [DW-1:0] v);
    return (~v) + {{(DW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [DW-1:0] f_inc(input logic [DW-1:0] v);
    return v + {{(DW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [DW-1:0] f_dec(input logic [DW-1:0] v);
    return v - {{(DW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [DW-1:0] f_shl1(input logic [DW-1:0] v);
    return {v[DW-2:0], 1'b0};
  endfunction

  function automatic logic f_not_below(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (a >= b);
  endfunction
endpackage

// File: rtl/absconv_ctrl.sv
module absconv_ctrl
  import absconv_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sgn,
  input  logic          k,
  output logic [NS-1:0] st,
  output logic          ld_ab,
  output logic          neg_b,
  output logic          step,
  output logic          ld_z,
  output logic          sh_z,
  output logic          done
);
  logic [NS-1:0] st_q, st_d;
  logic          done_q;

  always_comb begin
    st_d          = '0;
    st_d[ST_IDLE] = (st_q[ST_IDLE] & ~start) | st_q[ST_SH2];
    st_d[ST_LOAD] = st_q[ST_IDLE] & start;
    st_d[ST_SIGN] = st_q[ST_LOAD];
    st_d[ST_NEG]  = st_q[ST_SIGN] & sgn;
    st_d[ST_CMP]  = (st_q[ST_SIGN] & ~sgn) | st_q[ST_NEG] | st_q[ST_STEP];
    st_d[ST_STEP] = st_q[ST_CMP] & ~k;
    st_d[ST_ZLD]  = st_q[ST_CMP] & k;
    st_d[ST_SH1]  = st_q[ST_ZLD];
    st_d[ST_SH2]  = st_q[ST_SH1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= NS'(1) << ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b1;
    end else if (st_q[ST_LOAD]) begin
      done_q <= 1'b0;
    end else if (st_q[ST_SH2]) begin
      done_q <= 1'b1;
    end
  end

  assign st    = st_q;
  assign ld_ab = st_q[ST_LOAD];
  assign neg_b = st_q[ST_NEG];
  assign step  = st_q[ST_STEP];
  assign ld_z  = st_q[ST_ZLD];
  assign sh_z  = st_q[ST_SH1] | st_q[ST_SH2];
  assign done  = done_q;
endmodule

// File: rtl/absconv_dp.sv
module absconv_dp
  import absconv_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_ab,
  input  logic          neg_b,
  input  logic          step,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] y_in,
  output logic [DW-1:0] a,
  output logic [DW-1:0] b,
  output logic          sgn,
  output logic          k
);
  logic [DW-1:0] a_q, b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
    end else if (ld_ab) begin
      a_q <= x_in;
    end else if (step) begin
      a_q <= f_inc(a_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q <= '0;
    end else if (ld_ab) begin
      b_q <= y_in;
    end else if (neg_b) begin
      b_q <= f_negate(b_q);
    end else if (step) begin
      b_q <= f_dec(b_q);
    end
  end

  assign a   = a_q;
  assign b   = b_q;
  assign sgn = b_q[DW-1];
  assign k   = f_not_below(a_q, b_q);
endmodule

// File: rtl/absconv_zreg.sv
module absconv_zreg
  import absconv_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_z,
  input  logic          sh_z,
  input  logic [DW-1:0] a,
  output logic [DW-1:0] z
);
  logic [DW-1:0] z_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_q <= '0;
    end else if (ld_z) begin
      z_q <= a;
    end else if (sh_z) begin
      z_q <= f_shl1(z_q);
    end
  end

  assign z = z_q;
endmodule

// File: rtl/absconv_scale.sv
module absconv_scale
  import absconv_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] y_in,
  output logic [DW-1:0] z,
  output logic          done
);
  logic [NS-1:0] st_q;
  logic [DW-1:0] a_q, b_q;
  logic          sgn, k;
  logic          ev_load, ev_negate, ev_step, ev_zload, ev_shift;

  absconv_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .sgn   (sgn),
    .k     (k),
    .st    (st_q),
    .ld_ab (ev_load),
    .neg_b (ev_negate),
    .step  (ev_step),
    .ld_z  (ev_zload),
    .sh_z  (ev_shift),
    .done  (done)
  );

  absconv_dp u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_ab (ev_load),
    .neg_b (ev_negate),
    .step  (ev_step),
    .x_in  (x_in),
    .y_in  (y_in),
    .a     (a_q),
    .b     (b_q),
    .sgn   (sgn),
    .k     (k)
  );

  absconv_zreg u_zreg (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_z  (ev_zload),
    .sh_z  (ev_shift),
    .a     (a_q),
    .z     (z)
  );
endmodule

// File: rtl/absconv_chk.sv
module absconv_chk
  import absconv_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic [DW-1:0] z,
  input logic [NS-1:0] st,
  input logic [DW-1:0] a,
  input logic [DW-1:0] b,
  input logic          ev_load,
  input logic          ev_negate,
  input logic          ev_step,
  input logic          ev_zload,
  input logic          ev_shift
);
  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st) == 1);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st[ST_IDLE] && !start) |=> (st[ST_IDLE] && done && $stable(z)));

  p_done_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> !done);

  p_negate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_negate |=> (b == DW'((~$past(b)) + 1'b1)));

  p_step_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> (a == DW'($past(a) + 1'b1)) && (b == DW'($past(b) - 1'b1)));

  p_zload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zload |=> (z == $past(a)));

  p_zshift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_shift |=> (z == {$past(z[DW-2:0]), 1'b0}));
endmodule

bind absconv_scale absconv_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .z         (z),
  .st        (st_q),
  .a         (a_q),
  .b         (b_q),
  .ev_load   (ev_load),
  .ev_negate (ev_negate),
  .ev_step   (ev_step),
  .ev_zload  (ev_zload),
  .ev_shift  (ev_shift)
);

// File: tb/absconv_scale_tb_top.sv
module absconv_scale_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] x_in = '0;
  logic [7:0] y_in = '0;
  logic [7:0] z;
  logic       done;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic finished = 1'b0;

  typedef struct {
    int    zexp;
    int    lat;
    int    c0;
    string tag;
  } exp_t;
  exp_t sbq[$];

  always #2.5 clk = ~clk;

  absconv_scale dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .x_in  (x_in),
    .y_in  (y_in),
    .z     (z),
    .done  (done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // closed-form model: meeting point of the two registers
  function automatic void model(input int x, input int y, output int zz, output int lat);
    int mag, a, s, n;
    n   = (y >= 128) ? 1 : 0;
    mag = (y >= 128) ? 256 - y : y;
    if (x >= mag) begin
      a = x; s = 0;
    end else begin
      a = (x + mag + 1) / 2;
      s = (mag - x + 1) / 2;
    end
    zz  = (a * 4) % 256;
    lat = 6 + n + 2 * s;
  endfunction

  // monitor: pops on each rising done
  logic done_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && !done_prev) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R7 unexpected result", int'(z), -1);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(int'(z) == e.zexp, {"R7/R6 z ", e.tag}, int'(z), e.zexp);
          check(cyc - (e.c0 + 1) == e.lat, {"R8 latency ", e.tag}, cyc - (e.c0 + 1), e.lat);
        end
      end
      done_prev <= done;
    end
  end

  task automatic run_op(input int x, input int y, input bit noise, input string tag);
    exp_t e;
    int zz, lat, guard;
    model(x, y, zz, lat);
    @(negedge clk);
    x_in  = 8'(x);
    y_in  = 8'(y);
    start = 1'b1;
    e.zexp = zz; e.lat = lat; e.c0 = cyc; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(done == 1'b0, {"R3 done low ", tag}, int'(done), 0);
    if (noise) begin
      // R10: start pulses while busy are ignored
      start = 1'b1;
      x_in  = 8'hA5;
      y_in  = 8'h5A;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(done == 1'b1, {"R8 done returns ", tag}, int'(done), 1);
    @(negedge clk);
  endtask

  initial begin
    int zhold;
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R1 reset done", int'(done), 1);
    check(z == 8'd0, "R1 reset z", int'(z), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b1, "R1 idle after reset", int'(done), 1);

    run_op(5, 8'hFD, 1'b0, "R4 neg y, x above mag");
    run_op(0, 0, 1'b0, "R7 both zero");
    run_op(10, 20, 1'b0, "R5 even gap");
    run_op(10, 21, 1'b0, "R5 odd gap");
    run_op(0, 8'h80, 1'b0, "R4 y=-128 x=0");
    run_op(1, 8'h80, 1'b0, "R4 y=-128 x=1");
    run_op(255, 127, 1'b0, "R6 wrap 4x");
    run_op(3, 8'hF6, 1'b1, "R10 noise neg");
    run_op(2, 90, 1'b1, "R10 noise long loop");

    // R2: idle with start low holds state and result
    zhold = int'(z);
    repeat (6) @(negedge clk);
    check(done == 1'b1, "R2 idle done", int'(done), 1);
    check(int'(z) == zhold, "R2 idle z held", int'(z), zhold);

    for (int i = 0; i < 40; i++) begin
      int rx, ry;
      rx = int'($urandom_range(0, 255));
      ry = int'($urandom_range(0, 255));
      run_op(rx, ry, (i % 5) == 0, "R7 random");
    end

    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "R7 all results seen", sbq.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule